// File: doc/BRIEF.md
# Streaming UDP Header Screen

The block sits in a byte-wide receive path and judges each frame's Ethernet, IPv4 and UDP headers while the frame moves through. The bytes and the framing signals reach the output in the same cycle they arrive, unchanged. The ready signal from downstream goes straight back upstream. The block therefore adds no latency and no storage to the data path, and it never holds the stream back by itself.

The block keeps a position counter that advances only on accepted bytes. Byte by byte, it compares the destination address, the protocol type, the IP version and header length, a running ones'-complement checksum, the UDP destination port and the UDP length. When the last header byte is accepted, it raises a one-cycle strobe and presents a vector of seven pass flags. A frame that ends early raises the strobe on its final byte, and every check that has not yet seen all its bytes reports a fail. All state clears on the byte that carries `tlast`, so the next frame is judged from scratch.

Top module: `frame_hdr_check`

## Requirements
- R1: `m_tdata`, `m_tvalid` and `m_tlast` equal `s_tdata`, `s_tvalid` and `s_tlast` in the same cycle, and `s_tready` equals `m_tready`.
- R2: A byte is consumed only on a cycle where `s_tvalid` and `m_tready` are both high. Cycles without a transfer change no verdict and never raise `hdr_done`.
- R3: `pass_flags[0]` (address) is set only if bytes 0..5 equal `cfg_mac`, with byte 0 compared to `cfg_mac[47:40]` and byte 5 to `cfg_mac[7:0]`.
- R4: `pass_flags[1]` (type) is set only if byte 12 is 0x08 and byte 13 is 0x00.
- R5: For byte 14, `pass_flags[2]` requires the upper nibble to be 4 and `pass_flags[3]` requires the lower nibble to be 5.
- R6: `pass_flags[4]` requires the ones'-complement sum, with end-around carry, of the ten big-endian 16-bit words in bytes 14..33 to fold to 0xFFFF.
- R7: `pass_flags[5]` requires bytes 36..37, read big-endian, to equal `cfg_port`.
- R8: `pass_flags[6]` requires the big-endian value in bytes 38..39 to be at least 8 and to equal the big-endian value in bytes 16..17 minus 20, with no wraparound.
- R9: `hdr_done` is high for one cycle, on the transfer of byte 41. `pass_flags` is valid in that cycle, and no further pulse occurs before the frame's `tlast`.
- R10: If `tlast` is transferred at byte k < 41, `hdr_done` pulses on that transfer. Any check whose last byte offset is above k reports 0, and checks already complete report normally.
- R11: The transfer of a byte with `tlast` clears all parse state, so the verdict for the next frame depends only on that frame's bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mac | input | 48 | Expected destination address |
| cfg_port | input | 16 | Expected UDP destination port |
| s_tdata | input | 8 | Input stream byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input ready (forwarded from `m_tready`) |
| s_tlast | input | 1 | Input last byte of frame |
| m_tdata | output | 8 | Output stream byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Output last byte of frame |
| hdr_done | output | 1 | Header verdict strobe |
| pass_flags | output | 7 | Check results, bit 0 address to bit 6 UDP length |

## Verification
The hardest case to reach is a checksum that passes while another field in the same header fails. Random byte flips almost always break the checksum as well. For that reason the stimulus includes frames whose checksum is recomputed after a field is altered, such as a wrong header length, a total length below 20, or a shifted UDP length. Frames are also cut off at every offset around the last byte of each check. Random gaps in valid and in ready move every boundary byte through stalled cycles.

// File: rtl/fhc_pkg.sv
package fhc_pkg;

  localparam int MAC_BYTES = 6;
  localparam int IHL_REQ   = 5;
  localparam int IP_OFF    = 14;
  localparam int IP_LEN    = 4 * IHL_REQ;
  localparam int UDP_OFF   = IP_OFF + IP_LEN;
  localparam int HDR_LAST  = UDP_OFF + 7;
  localparam int HDR_LEN   = HDR_LAST + 1;
  localparam int POS_W     = $clog2(HDR_LEN + 1);

  typedef logic [POS_W-1:0] pos_t;

  localparam pos_t P_MAC_LAST = pos_t'(MAC_BYTES - 1);
  localparam pos_t P_ETY_HI   = pos_t'(12);
  localparam pos_t P_ETY_LO   = pos_t'(13);
  localparam pos_t P_IP_OFF   = pos_t'(IP_OFF);
  localparam pos_t P_TOT_HI   = pos_t'(IP_OFF + 2);
  localparam pos_t P_TOT_LO   = pos_t'(IP_OFF + 3);
  localparam pos_t P_IP_LAST  = pos_t'(UDP_OFF - 1);
  localparam pos_t P_DP_HI    = pos_t'(UDP_OFF + 2);
  localparam pos_t P_DP_LO    = pos_t'(UDP_OFF + 3);
  localparam pos_t P_UL_HI    = pos_t'(UDP_OFF + 4);
  localparam pos_t P_UL_LO    = pos_t'(UDP_OFF + 5);
  localparam pos_t P_HDR_LAST = pos_t'(HDR_LAST);
  localparam pos_t P_HDR_LEN  = pos_t'(HDR_LEN);

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [3:0]  IP_VER     = 4'd4;

  // bit 0 is the address check, bit 6 the UDP length check
  typedef struct packed {
    logic ulen;
    logic port;
    logic csum;
    logic ihl;
    logic ver;
    logic etype;
    logic mac;
  } chk_t;

  function automatic logic [15:0] ones_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic ulen_ok(input logic [15:0] ulen, input logic [15:0] tot);
    return (ulen >= 16'd8) && (({1'b0, ulen} + 17'(IP_LEN)) == {1'b0, tot});
  endfunction

endpackage

// File: rtl/fhc_pos_ctr.sv
module fhc_pos_ctr
  import fhc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic last,
  output pos_t pos
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (fire) begin
      if (last)                pos <= '0;
      else if (pos != P_HDR_LEN) pos <= pos + pos_t'(1);
    end
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= P_HDR_LEN);                                            // R9
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pos));                                      // R2
  AST_POS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (pos == '0));                              // R11

endmodule

// File: rtl/fhc_csum.sv
module fhc_csum
  import fhc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       last,
  input  pos_t       pos,
  input  logic [7:0] data,
  output logic       csum_bad_nxt
);

  logic [15:0] acc_q;
  logic [15:0] acc_sum;
  logic [7:0]  hi_q;
  logic        bad_q;
  logic        in_ip;
  logic        lo_byte;

  assign in_ip   = (pos >= P_IP_OFF) && (pos <= P_IP_LAST);
  assign lo_byte = pos[0] != P_IP_OFF[0];
  assign acc_sum = ones_add(acc_q, {hi_q, data});
  assign csum_bad_nxt = bad_q | (fire && (pos == P_IP_LAST) && (acc_sum != 16'hFFFF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      hi_q  <= '0;
      bad_q <= 1'b0;
    end else if (fire && last) begin
      acc_q <= '0;
      hi_q  <= '0;
      bad_q <= 1'b0;
    end else if (fire && in_ip) begin
      if (lo_byte) acc_q <= acc_sum;
      else         hi_q  <= data;
      bad_q <= csum_bad_nxt;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(acc_q));                                    // R2
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (acc_q == '0 && !bad_q));                  // R11

endmodule

// File: rtl/fhc_fields.sv
module fhc_fields
  import fhc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic        last,
  input  pos_t        pos,
  input  logic [7:0]  data,
  input  logic [47:0] cfg_mac,
  input  logic [15:0] cfg_port,
  output chk_t        bad_nxt
);

  chk_t        bad_q;
  logic [15:0] tot_q;
  logic [7:0]  port_hi_q;
  logic [7:0]  ulen_hi_q;
  logic [7:0]  mac_exp;

  always_comb begin
    mac_exp = '0;
    for (int i = 0; i < MAC_BYTES; i++)
      if (pos == pos_t'(i)) mac_exp = cfg_mac[8*(MAC_BYTES-1-i) +: 8];
  end

  always_comb begin
    bad_nxt = bad_q;
    if (fire) begin
      if (pos <= P_MAC_LAST && data != mac_exp)             bad_nxt.mac   = 1'b1;
      if (pos == P_ETY_HI && data != ETYPE_IPV4[15:8])      bad_nxt.etype = 1'b1;
      if (pos == P_ETY_LO && data != ETYPE_IPV4[7:0])       bad_nxt.etype = 1'b1;
      if (pos == P_IP_OFF && data[7:4] != IP_VER)           bad_nxt.ver   = 1'b1;
      if (pos == P_IP_OFF && data[3:0] != 4'(IHL_REQ))      bad_nxt.ihl   = 1'b1;
      if (pos == P_DP_LO && {port_hi_q, data} != cfg_port)  bad_nxt.port  = 1'b1;
      if (pos == P_UL_LO && !ulen_ok({ulen_hi_q, data}, tot_q)) bad_nxt.ulen = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_q     <= '0;
      tot_q     <= '0;
      port_hi_q <= '0;
      ulen_hi_q <= '0;
    end else if (fire) begin
      if (last) begin
        bad_q     <= '0;
        tot_q     <= '0;
        port_hi_q <= '0;
        ulen_hi_q <= '0;
      end else begin
        bad_q <= bad_nxt;
        if (pos == P_TOT_HI) tot_q[15:8] <= data;
        if (pos == P_TOT_LO) tot_q[7:0]  <= data;
        if (pos == P_DP_HI)  port_hi_q   <= data;
        if (pos == P_UL_HI)  ulen_hi_q   <= data;
      end
    end
  end

  AST_MAC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q.mac && !(fire && last)) |=> bad_q.mac);                // R3
  AST_FIELDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (bad_q == '0 && tot_q == '0));             // R11

endmodule

// File: rtl/frame_hdr_check.sv
module frame_hdr_check
  import fhc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] cfg_mac,
  input  logic [15:0] cfg_port,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  output logic        s_tready,
  input  logic        s_tlast,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  output logic        hdr_done,
  output logic [6:0]  pass_flags
);

  logic fire;
  pos_t pos;
  chk_t fld_bad;
  logic csum_bad;
  chk_t bad_all;
  chk_t complete;

  assign m_tdata  = s_tdata;
  assign m_tvalid = s_tvalid;
  assign m_tlast  = s_tlast;
  assign s_tready = m_tready;
  assign fire     = s_tvalid & m_tready;

  fhc_pos_ctr u_pos (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fire),
    .last (s_tlast),
    .pos  (pos)
  );

  fhc_csum u_csum (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .last        (s_tlast),
    .pos         (pos),
    .data        (s_tdata),
    .csum_bad_nxt(csum_bad)
  );

  fhc_fields u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .last    (s_tlast),
    .pos     (pos),
    .data    (s_tdata),
    .cfg_mac (cfg_mac),
    .cfg_port(cfg_port),
    .bad_nxt (fld_bad)
  );

  always_comb begin
    bad_all      = fld_bad;
    bad_all.csum = csum_bad;
    complete.mac   = pos >= P_MAC_LAST;
    complete.etype = pos >= P_ETY_LO;
    complete.ver   = pos >= P_IP_OFF;
    complete.ihl   = pos >= P_IP_OFF;
    complete.csum  = pos >= P_IP_LAST;
    complete.port  = pos >= P_DP_LO;
    complete.ulen  = pos >= P_UL_LO;
  end

  assign pass_flags = complete & ~bad_all;
  assign hdr_done   = fire && ((pos == P_HDR_LAST) || (s_tlast && pos < P_HDR_LAST));

  AST_DONE_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> (s_tvalid && s_tready));                         // R2
  AST_NO_DONE_PAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == P_HDR_LEN) |-> !hdr_done);                            // R9
  AST_SHORT_ULEN_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && pos < P_UL_LO) |-> !pass_flags[6]);              // R10
  AST_SHORT_CSUM_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && pos < P_IP_LAST) |-> !pass_flags[4]);            // R10

endmodule

// File: tb/test_frame_hdr_check.sv
`timescale 1ns/1ps
module test_frame_hdr_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] cfg_mac = 48'h02_1A_2B_3C_4D_5E;
  logic [15:0] cfg_port = 16'd5001;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic        s_tlast = 1'b0;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;
  logic        m_tlast;
  logic        hdr_done;
  logic [6:0]  pass_flags;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [7:0] fr [0:63];
  int flen;

  always #4 clk = ~clk;

  frame_hdr_check i_frame_hdr_check (
    .clk(clk), .rst_n(rst_n), .cfg_mac(cfg_mac), .cfg_port(cfg_port),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .hdr_done(hdr_done), .pass_flags(pass_flags)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int b);
    case (b)
      0: return "R3 address";
      1: return "R4 type";
      2: return "R5 version";
      3: return "R5 length";
      4: return "R6 checksum";
      5: return "R7 port";
      default: return "R8 udp length";
    endcase
  endfunction

  function automatic logic [15:0] w16(input int i);
    return {fr[i], fr[i+1]};
  endfunction

  function automatic logic sum_good();
    int s = 0;
    for (int i = 0; i < 10; i++) s += int'(w16(14 + 2*i));
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return s == 32'hFFFF;
  endfunction

  // expected flags when the header ends at byte e
  function automatic logic [6:0] exp_flags(input int e);
    logic [6:0] f = '0;
    logic m = 1'b1;
    int t, u;
    for (int i = 0; i < 6; i++) if (fr[i] != cfg_mac[47-8*i -: 8]) m = 1'b0;
    f[0] = (e >= 5) && m;
    f[1] = (e >= 13) && fr[12] == 8'h08 && fr[13] == 8'h00;
    f[2] = (e >= 14) && fr[14][7:4] == 4'd4;
    f[3] = (e >= 14) && fr[14][3:0] == 4'd5;
    f[4] = (e >= 33) && sum_good();
    f[5] = (e >= 37) && w16(36) == cfg_port;
    t = int'(w16(16));
    u = int'(w16(38));
    f[6] = (e >= 39) && u >= 8 && t >= 20 && u == t - 20;
    return f;
  endfunction

  task automatic fix_csum();
    int s = 0;
    logic [15:0] c;
    fr[24] = 8'h00; fr[25] = 8'h00;
    for (int i = 0; i < 10; i++) s += int'(w16(14 + 2*i));
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    c = ~s[15:0];
    fr[24] = c[15:8]; fr[25] = c[7:0];
  endtask

  task automatic build_good(input int pay);
    logic [15:0] tot, ul;
    for (int i = 0; i < 64; i++) fr[i] = 8'($urandom);
    for (int i = 0; i < 6; i++) fr[i] = cfg_mac[47-8*i -: 8];
    fr[12] = 8'h08; fr[13] = 8'h00; fr[14] = 8'h45; fr[23] = 8'd17;
    tot = 16'(28 + pay); ul = 16'(8 + pay);
    fr[16] = tot[15:8]; fr[17] = tot[7:0];
    fr[36] = cfg_port[15:8]; fr[37] = cfg_port[7:0];
    fr[38] = ul[15:8]; fr[39] = ul[7:0];
    fix_csum();
    flen = 42 + pay;
  endtask

  task automatic send_frame();
    logic [6:0] ef;
    bit exp_done;
    for (int i = 0; i < flen; i++) begin
      while ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        s_tvalid = 1'b0;
        m_tready = 1'($urandom);
        #1;
        check("R2 idle no strobe", 64'(hdr_done), 64'(0));
      end
      do begin
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = fr[i];
        s_tlast  = (i == flen - 1);
        m_tready = ($urandom_range(0, 3) != 0);
        #1;
        check("R1 forward", {m_tdata, m_tvalid, m_tlast, s_tready},
              {s_tdata, 1'b1, s_tlast, m_tready});
        if (m_tready) begin
          exp_done = (i == 41) || (i == flen - 1 && i < 41);
          check(i < 41 ? "R10 short strobe" : "R9 strobe", 64'(hdr_done), 64'(exp_done));
          if (exp_done) begin
            ef = exp_flags(i);
            for (int b = 0; b < 7; b++)
              check(i < 41 ? {req_of(b), " R10"} : req_of(b), 64'(pass_flags[b]), 64'(ef[b]));
          end
        end else begin
          check("R2 stalled no strobe", 64'(hdr_done), 64'(0));
        end
      end while (!m_tready);
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    int kind, k;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset valid", 64'(m_tvalid), 64'(0));
    check("R9 reset strobe", 64'(hdr_done), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    build_good(0); send_frame();                               // R9 tlast on byte 41
    build_good(4); fr[5] ^= 8'h01; send_frame();               // R3
    build_good(2); fr[12] = 8'h86; fr[13] = 8'hDD; send_frame(); // R4
    build_good(3); fr[14] = 8'h46; fix_csum(); send_frame();   // R5
    build_good(1); fr[20] ^= 8'h40; send_frame();              // R6
    build_good(5); fr[37] ^= 8'h10; send_frame();              // R7
    build_good(0); fr[16] = 8'h00; fr[17] = 8'd27;
    fr[38] = 8'h00; fr[39] = 8'd7; fix_csum(); send_frame();   // R8 below minimum
    build_good(0); fr[16] = 8'h00; fr[17] = 8'h00;
    fr[38] = 8'hFF; fr[39] = 8'hEC; fix_csum(); send_frame();  // R8 no wraparound
    build_good(0); flen = 1; send_frame();                     // R10 one byte
    build_good(0); flen = 40; send_frame();                    // R10 ulen complete
    build_good(0); flen = 39; send_frame();                    // R10 ulen missing
    build_good(0); flen = 34; send_frame();                    // R10 csum boundary
    build_good(6); send_frame();                               // R11 clean after short

    // random frames
    for (int n = 0; n < 160; n++) begin
      if (n == 80) cfg_port = 16'd53;
      build_good($urandom_range(0, 12));
      kind = $urandom_range(0, 5);
      case (kind)
        1: begin k = $urandom_range(0, 41); fr[k] ^= 8'($urandom_range(1, 255)); end
        2: flen = $urandom_range(1, 41);
        3: for (int i = 0; i < 42; i++) if ($urandom_range(0, 7) == 0) fr[i] = 8'($urandom);
        4: begin v = 16'($urandom_range(0, 60)); fr[16] = v[15:8]; fr[17] = v[7:0]; fix_csum(); end
        5: begin k = $urandom_range(14, 33); fr[k] ^= 8'($urandom_range(1, 255)); fix_csum(); end
        default: ;
      endcase
      send_frame();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule